// File: doc/BRIEF.md
# Interleaved Multichannel FIR Filter

This block runs one four-tap FIR filter for several slow channels whose samples share one fast stream. Each valid input cycle brings a signed sample together with its channel index. The block multiplies the current sample and that channel's three older samples by a fixed set of coefficients, adds the products at full precision, and returns the result tagged with the same channel index two cycles later.

The filter holds no separate copy of the datapath for each channel. Each delay element between taps is a shift stage as deep as the channel count. As long as channels arrive in strict rotation (0, 1, ..., N-1, 0, ...), the value at the end of every stage is the same channel's sample from one round earlier. A two-state sequencer keeps that rotation intact. In state ALIGN it waits for the first valid sample of channel 0. On that sample it moves to STREAM (transition ALIGN→STREAM) and stays there until reset (transition STREAM→STREAM). In STREAM it accepts only the channel it expects next. Reset returns the sequencer to ALIGN.

Top module: `mcfir_top`

## Requirements
- R1: Reset (synchronous, active high) clears all delay storage and the pipeline. After reset, out_valid is 0 and out_data is 0. The first result of every channel then equals k0 times its first sample, because its older samples read as zero.
- R2: In ALIGN, a valid sample is accepted only if its index is 0. In STREAM, a valid sample is accepted only if its index equals the expected channel, which counts 0..N-1 cyclically from the last accepted index. A sample that is not accepted gives no output and leaves all delay storage unchanged.
- R3: For an accepted sample x of channel c, out_data = k0·x[n] + k1·x[n-1] + k2·x[n-2] + k3·x[n-3]. Here x[n-i] is channel c's i-th earlier accepted sample. The coefficients are k0=-256, k1=255, k2=100 and k3=-37. Inputs and coefficients are 9-bit signed two's complement. The result is 20-bit signed and is neither rounded nor truncated.
- R4: out_valid rises exactly two clock edges after the edge that accepts a sample, and out_ch then equals that sample's channel index.
- R5: A cycle with in_valid low advances no delay stage and produces no output.
- R6: Consecutive results come out in cyclic channel order, so that channel N-1 is followed by channel 0.
- R7: While out_valid is low, out_data holds its last value.
- R8: The result for each channel depends only on that channel's own samples, even when the values in the other channels differ widely.
- R9: Full-scale inputs (-256 and +255 held on all taps) produce the exact sum without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | CH_W (2) | Channel index of the input sample |
| in_data | input | 9 | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_ch | output | CH_W (2) | Channel index of the result |
| out_data | output | 20 | Signed full-precision result |

## Verification
The bench first sends channel indices before any channel 0 appears, to show that ALIGN rejects them. It then feeds fresh rounds with no history, where each output must equal k0 times the input and so exposes a wrong tap or a wrong coefficient. A long random run interleaves idle cycles and out-of-turn indices with the in-turn samples. This pattern separates correct per-channel delay from delay stages that shift on rejected or idle cycles, because any extra shift puts another channel's sample on a tap. Full-scale runs at both rails test sign extension and guard bits. A single busy channel among zeroed channels tests isolation, and a reset in mid-run tests that storage is cleared.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;

    typedef enum logic {
        SEQ_ALIGN,
        SEQ_STREAM
    } seq_state_e;

    function automatic int tap_coef(input int idx);
        case (idx)
            0:       return -256;
            1:       return 255;
            2:       return 100;
            3:       return -37;
            default: return idx;
        endcase
    endfunction

endpackage

// File: rtl/mcfir_seq.sv
module mcfir_seq
    import mcfir_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_ch,
    output logic            accept
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_e      state_q, state_d;
    logic [CH_W-1:0] want_q;

    // state register and expected channel
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_ALIGN;
            want_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                want_q <= (in_ch == LAST_CH) ? '0 : in_ch + 1'b1;
            end
        end
    end

    // outputs and next state
    always_comb begin
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            SEQ_ALIGN: begin
                accept = in_valid && (in_ch == '0);
                if (accept) state_d = SEQ_STREAM;
            end
            SEQ_STREAM: begin
                accept = in_valid && (in_ch == want_q);
            end
        endcase
    end

endmodule

// File: rtl/mcfir_delay.sv
module mcfir_delay #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout
);

    logic signed [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
        end else if (shift) begin
            slot_q[0] <= din;
            for (int j = 1; j < DEPTH; j++) slot_q[j] <= slot_q[j-1];
        end
    end

    assign dout = slot_q[DEPTH-1];

endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac
    import mcfir_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int DATA_W = 9,
    parameter int COEF_W = 9,
    parameter int CH_W   = 2,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [CH_W-1:0]          ch,
    input  logic signed [DATA_W-1:0] taps [TAPS],
    output logic                     res_valid,
    output logic [CH_W-1:0]          res_ch,
    output logic signed [ACC_W-1:0]  res_data
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod_q [TAPS];
    logic signed [ACC_W-1:0]  chain  [TAPS+1];
    logic                     v1_q;
    logic [CH_W-1:0]          ch1_q;

    // chain seeded with zero
    assign chain[0] = '0;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        localparam logic signed [COEF_W-1:0] K = COEF_W'(tap_coef(i));
        always_ff @(posedge clk) begin
            if (rst)     prod_q[i] <= '0;
            else if (en) prod_q[i] <= taps[i] * K;
        end
        assign chain[i+1] = chain[i] + ACC_W'(prod_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q      <= 1'b0;
            ch1_q     <= '0;
            res_valid <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            v1_q      <= en;
            res_valid <= v1_q;
            if (en) ch1_q <= ch;
            if (v1_q) begin
                res_ch   <= ch1_q;
                res_data <= chain[TAPS];
            end
        end
    end

endmodule

// File: rtl/mcfir_top.sv
module mcfir_top #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 9,
    parameter int COEF_W = 9,
    parameter int TAPS   = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_ch,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic [CH_W-1:0]          out_ch,
    output logic signed [ACC_W-1:0]  out_data
);

    logic                     accept;
    logic signed [DATA_W-1:0] tap_v [TAPS];

    mcfir_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ch    (in_ch),
        .accept   (accept)
    );

    assign tap_v[0] = in_data;

    for (genvar s = 1; s < TAPS; s++) begin : g_stage
        mcfir_delay #(.DEPTH(NUM_CH), .DATA_W(DATA_W)) u_dly (
            .clk   (clk),
            .rst   (rst),
            .shift (accept),
            .din   (tap_v[s-1]),
            .dout  (tap_v[s])
        );
    end

    mcfir_mac #(
        .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
        .CH_W(CH_W), .ACC_W(ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .en        (accept),
        .ch        (in_ch),
        .taps      (tap_v),
        .res_valid (out_valid),
        .res_ch    (out_ch),
        .res_data  (out_data)
    );

endmodule

// File: rtl/mcfir_chk.sv
module mcfir_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int ACC_W  = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    accept,
    input logic [CH_W-1:0]         in_ch,
    input logic                    out_valid,
    input logic [CH_W-1:0]         out_ch,
    input logic signed [ACC_W-1:0] out_data
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 out_valid);

    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |-> ##2 !out_valid);

    // R4
    chan_tag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ch == $past(in_ch, 2));

    // R6
    chan_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |->
            out_ch == (($past(out_ch) == LAST_CH) ? '0 : $past(out_ch) + 1'b1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_data));

endmodule

bind mcfir_top mcfir_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ACC_W(ACC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .in_ch     (in_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data)
);

// File: tb/mcfir_top_tb_top.sv
module mcfir_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WATCHDOG   = 100000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [1:0]         in_ch = '0;
    logic signed [8:0]  in_data = '0;
    logic               out_valid;
    logic [1:0]         out_ch;
    logic signed [19:0] out_data;

    mcfir_top #(.NUM_CH(N)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
        .in_data(in_data), .out_valid(out_valid), .out_ch(out_ch),
        .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp  = 0;
    int n_fail = 0;
    int cyc    = 0;
    string tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    // reference model
    int  k [4] = '{-256, 255, 100, -37};
    int  hist [N][4];
    bit  aligned = 0;
    int  want = 0;
    int  q_data [$];
    int  q_ch   [$];
    int  q_due  [$];
    int  last_data = 0;

    function automatic int fir_of(int c);
        int s = 0;
        for (int i = 0; i < 4; i++) s += k[i] * hist[c][i];
        return s;
    endfunction

    task automatic check(string rq, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        for (int c = 0; c < N; c++)
            for (int i = 0; i < 4; i++) hist[c][i] = 0;
        aligned = 0;
        want = 0;
        q_data.delete(); q_ch.delete(); q_due.delete();
        last_data = 0;
    endtask

    // drive one cycle at a negedge
    task automatic drive(bit v, int ch, int d);
        bit acc;
        @(negedge clk);
        in_valid = v;
        in_ch    = 2'(ch);
        in_data  = 9'(d);
        acc = v && (aligned ? (ch == want) : (ch == 0));
        if (acc) begin
            aligned = 1;
            want = (ch + 1) % N;
            for (int i = 3; i > 0; i--) hist[ch][i] = hist[ch][i-1];
            hist[ch][0] = d;
            q_data.push_back(fir_of(ch));
            q_ch.push_back(ch);
            q_due.push_back(cyc + 2);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0);
    endtask

    task automatic do_reset();
        idle(3);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: cleared output after reset
        check("R1 valid", int'(out_valid), 0);
        check("R1 data", int'(out_data), 0);
    endtask

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (out_valid) begin
                    if (q_data.size() == 0) begin
                        // R2/R5: output with nothing accepted
                        check("R2/R5 unexpected out_valid", 1, 0);
                    end else begin
                        check({tag, " data"}, int'(out_data), q_data[0]);
                        check("R4 channel", int'(out_ch), q_ch[0]);
                        check("R4 latency", cyc, q_due[0]);
                        void'(q_data.pop_front());
                        void'(q_ch.pop_front());
                        void'(q_due.pop_front());
                    end
                    last_data = int'(out_data);
                end else begin
                    // R7: hold while idle
                    check("R7 hold", int'(out_data), last_data);
                    if (q_due.size() != 0 && q_due[0] <= cyc)
                        check("R4 missing output", 0, 1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 data", int'(out_data), 0);

        // R2: indices other than 0 ignored while aligning
        tag = "R2";
        drive(1, 1, 50);
        drive(1, 3, 70);
        drive(1, 2, -9);
        idle(3);

        // R1: fresh history, output = k0*x
        tag = "R1";
        for (int c = 0; c < N; c++) drive(1, c, 10 + c);
        idle(3);

        // R3/R5/R2: random stream with gaps and out-of-turn indices
        tag = "R3";
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 8);
            int d = int'($urandom % 512) - 256;
            if (r == 0)      drive(0, want, d);
            else if (r == 1) drive(1, (want + 1 + int'($urandom % 3)) % N, d);
            else             drive(1, want, d);
        end
        idle(3);

        // R9: full scale at both rails
        tag = "R9";
        for (int rd = 0; rd < 5; rd++)
            for (int c = 0; c < N; c++) drive(1, c, -256);
        for (int rd = 0; rd < 5; rd++)
            for (int c = 0; c < N; c++) drive(1, c, 255);
        for (int rd = 0; rd < 4; rd++)
            for (int c = 0; c < N; c++) drive(1, c, (rd % 2) ? -256 : 255);
        idle(3);

        // R8: one busy channel among zero channels
        tag = "R8";
        for (int rd = 0; rd < 6; rd++)
            for (int c = 0; c < N; c++) drive(1, c, (c == 2) ? 200 - 77 * rd : 0);
        idle(3);

        // R1: reset mid-run clears storage
        for (int c = 0; c < N; c++) drive(1, c, 123);
        do_reset();
        tag = "R1";
        for (int c = 0; c < N; c++) drive(1, c, -100 + c);
        // R6: cyclic order continues across rounds
        tag = "R6";
        for (int rd = 0; rd < 3; rd++)
            for (int c = 0; c < N; c++) drive(1, c, int'($urandom % 512) - 256);
        idle(5);

        if (q_data.size() != 0) check("R4 outstanding results", q_data.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule